// File: doc/BRIEF.md
# Two-Channel Sequenced Break Counter

This block is a debug trigger. It watches two one-cycle match strobes, channel A and channel B, which come from comparators outside the block. It raises a sticky break request toward the exception logic. A control register picks one of two modes:

- **Independent mode:** either channel can fire.
- **Sequential mode:** channel B counts only after channel A has armed it.

Channel B can also be held back by a countdown. A 12-bit count register drops by one on each qualifying B match, and the break fires on the match that finds the count at 1 (or already at 0).

Software reaches the control, count and status registers through a plain write port and a combinational read port. Both ports take an access on every cycle, so there is no valid/ready handshake and no back-pressure at any pin. The match strobes are single-cycle events and are never stalled. Reads have no side effects. The break is cleared by writing the status register.

Top module: `brk_seq_unit`

## Requirements
- R1: After reset, `break_o` is 0 and the control, count and status registers all read 0.
- R2: Control register (address 0) layout:
  - bit 0 enables the count gate on channel B.
  - bit 2 selects sequential mode when 1.
  - All other bits read 0 whatever was written.
- R3: The count register (address 1) holds CNT_W = 12 bits. Writing 0xFFFF reads back 0x0FFF: bits 15..12 read 0 and writes to them are ignored.
- R4: In independent mode:
  - a match on A sets `break_o` and status bit 0 on the next cycle.
  - a match on B with the gate off sets `break_o` and status bit 1 on the next cycle.
- R5: With the gate on, a qualifying B match while the count is above 1 lowers the count by one and does not raise `break_o`.
- R6: With the gate on, a qualifying B match while the count is 1 raises `break_o` and leaves the count at 0.
- R7: With the gate on, a qualifying B match while the count is 0 raises `break_o` at once, and the count stays 0.
- R8: In sequential mode:
  - an A match only sets the armed flag (status bit 2) and never breaks.
  - B matches are ignored (no count change, no break) while the flag is clear.
  - A and B on the same cycle while disarmed arms only.
- R9: The armed flag clears when B issues a break, or when a control write changes bit 2. A mode change clears the flag even if A matches on the same cycle.
- R10: `break_o` stays high until a status write (address 2) with bit 0 set. A new break in the same cycle as that clear wins and leaves `break_o` and its cause bit set.
- R11: A count-register write in the same cycle as a decrement loads the written value.
- R12: `rd_data` follows `rd_addr` in the same cycle. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| match_a | input | 1 | Channel A condition met this cycle |
| match_b | input | 1 | Channel B condition met this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| break_o | output | 1 | Sticky break request |

## Verification
The bench builds the block with its default parameters, DATA_W = 16 and CNT_W = 12. This makes the top count of 4095 and the masking of bits 15..12 directly observable. Random count loads are kept small, so counts of 0, 1 and 2 occur often. That brings the decrement, last-match and zero-count paths within reach in both modes, alongside mode flips while armed and clears that collide with new breaks.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd2;
  localparam int CTRL_GATE_BIT = 0;
  localparam int CTRL_SEQ_BIT  = 2;
  localparam int ST_CLR_BIT    = 0;

  typedef struct packed {
    logic seq_mode;
    logic cnt_gate;
  } ctrl_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dec_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              mode_change_o,
  output logic              clr_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic wr_ctrl, wr_count;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] count_q;

  assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_count = wr_en && (wr_addr == ADR_COUNT);
  assign clr_o    = wr_en && (wr_addr == ADR_STATUS) && wr_data[ST_CLR_BIT];
  assign mode_change_o = wr_ctrl && (wr_data[CTRL_SEQ_BIT] != ctrl_q.seq_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.seq_mode <= wr_data[CTRL_SEQ_BIT];
      ctrl_q.cnt_gate <= wr_data[CTRL_GATE_BIT];
    end
  end

  // software write has priority over the match-driven decrement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (wr_count) count_q <= wr_data[CNT_W-1:0];
    else if (dec_i)    count_q <= count_q - ONE;
  end

  assign ctrl_o  = ctrl_q;
  assign count_o = count_q;

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> count_q == $past(wr_data[CNT_W-1:0]));
  a_r5_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !wr_count) |=> count_q == $past(count_q) - ONE);
  a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !wr_count) |=> count_q == '0);
endmodule

// File: rtl/brk_arm.sv
module brk_arm
  import brk_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             match_a,
  input  logic             match_b,
  input  logic             mode_change_i,
  output logic             a_fire_o,
  output logic             b_fire_o,
  output logic             dec_o,
  output logic             armed_o
);
  logic armed_q, b_qual, count_last;

  assign b_qual     = match_b && (!ctrl_i.seq_mode || armed_q);
  assign count_last = (count_i[CNT_W-1:1] == '0);  // count is 0 or 1
  assign a_fire_o   = match_a && !ctrl_i.seq_mode;
  assign b_fire_o   = b_qual && (!ctrl_i.cnt_gate || count_last);
  assign dec_o      = b_qual && ctrl_i.cnt_gate && (count_i != '0);

  // mode change clears first, then a new A re-arms, then a B break disarms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          armed_q <= 1'b0;
    else if (mode_change_i)              armed_q <= 1'b0;
    else if (ctrl_i.seq_mode && match_a) armed_q <= 1'b1;
    else if (b_fire_o)                   armed_q <= 1'b0;
  end

  assign armed_o = armed_q;

  a_r9_mode_change_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change_i |=> !armed_q);
  a_r9_break_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (b_fire_o && ctrl_i.seq_mode && !match_a && !mode_change_i) |=> !armed_q);
  a_r8_no_a_break_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.seq_mode && !armed_q) |-> !(b_fire_o || dec_o));
endmodule

// File: rtl/brk_latch.sv
module brk_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic a_fire_i,
  input  logic b_fire_i,
  input  logic clr_i,
  output logic brk_o,
  output logic cause_a_o,
  output logic cause_b_o
);
  logic brk_q, ca_q, cb_q;

  // set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      ca_q  <= 1'b0;
      cb_q  <= 1'b0;
    end else begin
      brk_q <= (brk_q && !clr_i) || a_fire_i || b_fire_i;
      ca_q  <= (ca_q && !clr_i) || a_fire_i;
      cb_q  <= (cb_q && !clr_i) || b_fire_i;
    end
  end

  assign brk_o     = brk_q;
  assign cause_a_o = ca_q;
  assign cause_b_o = cb_q;

  a_r10_break_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !clr_i) |=> brk_q);
  a_r4_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (a_fire_i || b_fire_i) |=> brk_q);
  a_r10_cause_implies_break: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_q || cb_q) |-> brk_q);
endmodule

// File: rtl/brk_seq_unit.sv
module brk_seq_unit
  import brk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_a,
  input  logic              match_b,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              break_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  ctrl_t ctrl;
  logic [CNT_W-1:0] count;
  logic mode_change, clr, a_fire, b_fire, dec, armed, cause_a, cause_b;

  brk_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dec_i(dec), .ctrl_o(ctrl), .count_o(count),
    .mode_change_o(mode_change), .clr_o(clr)
  );

  brk_arm #(.CNT_W(CNT_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .count_i(count),
    .match_a(match_a), .match_b(match_b), .mode_change_i(mode_change),
    .a_fire_o(a_fire), .b_fire_o(b_fire), .dec_o(dec), .armed_o(armed)
  );

  brk_latch u_latch (
    .clk(clk), .rst_n(rst_n), .a_fire_i(a_fire), .b_fire_i(b_fire),
    .clr_i(clr), .brk_o(break_o), .cause_a_o(cause_a), .cause_b_o(cause_b)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_CTRL: begin
        rd_data[CTRL_GATE_BIT] = ctrl.cnt_gate;
        rd_data[CTRL_SEQ_BIT]  = ctrl.seq_mode;
      end
      ADR_COUNT:  rd_data = {{PAD_W{1'b0}}, count};
      ADR_STATUS: rd_data[2:0] = {armed, cause_b, cause_a};
      default:    rd_data = '0;
    endcase
  end

  a_r12_spare_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> rd_data == '0);
endmodule

// File: tb/brk_seq_unit_tb.sv
module brk_seq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic match_a = 0, match_b = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic break_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  bit m_seq, m_gate, m_armed, m_brk, m_ca, m_cb;
  logic [11:0] m_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_seq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .break_o(break_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return {13'd0, m_seq, 1'b0, m_gate};
      2'd1: return {4'd0, m_count};
      2'd2: return {13'd0, m_armed, m_cb, m_ca};
      default: return 16'd0;
    endcase
  endfunction

  // one clock edge of the reference, using pre-edge state
  task automatic model_step(bit a, bit b, bit we, logic [1:0] ad, logic [15:0] d);
    bit wctrl, wcnt, clr, bq, bf, af, dec, mchg;
    wctrl = we && ad == 2'd0;
    wcnt  = we && ad == 2'd1;
    clr   = we && ad == 2'd2 && d[0];
    mchg  = wctrl && (d[2] != m_seq);
    bq  = b && (!m_seq || m_armed);
    bf  = bq && (!m_gate || m_count <= 12'd1);
    af  = a && !m_seq;
    dec = bq && m_gate && m_count != 0;
    if (mchg) m_armed = 0;
    else if (m_seq && a) m_armed = 1;
    else if (bf) m_armed = 0;
    if (wcnt) m_count = d[11:0];
    else if (dec) m_count = m_count - 12'd1;
    m_brk = (m_brk && !clr) || af || bf;
    m_ca  = (m_ca && !clr) || af;
    m_cb  = (m_cb && !clr) || bf;
    if (wctrl) begin m_seq = d[2]; m_gate = d[0]; end
  endtask

  task automatic cycle(bit a, bit b, bit we, logic [1:0] ad, logic [15:0] d, string req);
    @(negedge clk);
    match_a = a; match_b = b; wr_en = we; wr_addr = ad; wr_data = d;
    @(posedge clk);
    model_step(a, b, we, ad, d);
    #1;
    match_a = 0; match_b = 0; wr_en = 0;
    chk({req, " break_o"}, {15'd0, break_o}, {15'd0, m_brk});
    for (int k = 0; k < 3; k++) begin
      rd_addr = 2'(k); #1;
      chk({req, " read"}, rd_data, model_read(2'(k)));
    end
  endtask

  task automatic wr(logic [1:0] ad, logic [15:0] d, string req);
    cycle(0, 0, 1, ad, d, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_seq = 0; m_gate = 0; m_armed = 0; m_brk = 0; m_ca = 0; m_cb = 0; m_count = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 break_o", {15'd0, break_o}, 16'd0);
    for (int k = 0; k < 3; k++) begin
      rd_addr = 2'(k); #1; chk("R1 reg", rd_data, 16'd0);
    end
    // R12 spare address
    rd_addr = 2'd3; #1; chk("R12 spare", rd_data, 16'd0);
    // R2 reserved control bits
    wr(2'd0, 16'hFFFF, "R2");
    rd_addr = 2'd0; #1; chk("R2 ctrl", rd_data, 16'h0005);
    wr(2'd0, 16'h0000, "R2");
    // R3 count width
    wr(2'd1, 16'hFFFF, "R3");
    rd_addr = 2'd1; #1; chk("R3 count", rd_data, 16'h0FFF);
    // R4 independent A and B
    cycle(1, 0, 0, 0, 0, "R4 A");
    rd_addr = 2'd2; #1; chk("R4 cause A", rd_data, 16'h0001);
    wr(2'd2, 16'h0001, "R10 clear");
    chk("R10 cleared", {15'd0, break_o}, 16'd0);
    cycle(0, 1, 0, 0, 0, "R4 B");
    rd_addr = 2'd2; #1; chk("R4 cause B", rd_data, 16'h0002);
    // R10 set beats clear
    cycle(1, 0, 1, 2'd2, 16'h0001, "R10 collide");
    chk("R10 set wins", {15'd0, break_o}, 16'd1);
    wr(2'd2, 16'h0001, "R10 clear");
    // R5, R6 countdown in independent mode
    wr(2'd0, 16'h0001, "R5 gate on");
    wr(2'd1, 16'h0003, "R5 load");
    cycle(0, 1, 0, 0, 0, "R5 dec");
    rd_addr = 2'd1; #1; chk("R5 count", rd_data, 16'h0002);
    chk("R5 no break", {15'd0, break_o}, 16'd0);
    cycle(0, 1, 0, 0, 0, "R5 dec");
    cycle(0, 1, 0, 0, 0, "R6 last");
    chk("R6 break", {15'd0, break_o}, 16'd1);
    rd_addr = 2'd1; #1; chk("R6 count zero", rd_data, 16'h0000);
    wr(2'd2, 16'h0001, "R10 clear");
    // R7 zero count
    cycle(0, 1, 0, 0, 0, "R7 zero");
    chk("R7 break", {15'd0, break_o}, 16'd1);
    rd_addr = 2'd1; #1; chk("R7 count", rd_data, 16'h0000);
    wr(2'd2, 16'h0001, "R10 clear");
    // R11 write beats decrement
    wr(2'd1, 16'h0005, "R11 load");
    cycle(0, 1, 1, 2'd1, 16'h0009, "R11 collide");
    rd_addr = 2'd1; #1; chk("R11 count", rd_data, 16'h0009);
    // R8 sequential mode
    wr(2'd0, 16'h0004, "R8 seq");
    cycle(0, 1, 0, 0, 0, "R8 B unarmed");
    chk("R8 no break", {15'd0, break_o}, 16'd0);
    cycle(1, 1, 0, 0, 0, "R8 A+B unarmed");
    chk("R8 arm only", {15'd0, break_o}, 16'd0);
    rd_addr = 2'd2; #1; chk("R8 armed", rd_data, 16'h0004);
    cycle(0, 1, 0, 0, 0, "R9 B break");
    rd_addr = 2'd2; #1; chk("R9 disarmed", rd_data, 16'h0002);
    wr(2'd2, 16'h0001, "R10 clear");
    cycle(1, 0, 0, 0, 0, "R9 arm");
    cycle(1, 0, 1, 2'd0, 16'h0000, "R9 mode change");
    rd_addr = 2'd2; #1; chk("R9 mode clears", rd_data, 16'h0000);
    // random phase against the reference (R4 R5 R6 R7 R8 R9 R10 R11)
    for (int i = 0; i < 4000; i++) begin
      bit a, b, we;
      logic [1:0] ad;
      logic [15:0] d;
      a  = ($urandom_range(0, 3) == 0);
      b  = ($urandom_range(0, 2) == 0);
      we = ($urandom_range(0, 5) == 0);
      ad = 2'($urandom_range(0, 3));
      case (ad)
        2'd1: d = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'($urandom_range(0, 4));
        2'd2: d = 16'($urandom_range(0, 1));
        default: d = 16'($urandom_range(0, 7));
      endcase
      cycle(a, b, we, ad, d, "R4/R5/R6/R7/R8/R9/R10/R11 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule